// File: doc/BRIEF.md
# BCD Clock Calendar Counter Chain

This block is the timekeeping core of a real-time clock. An oscillator strobe is divided down to a centisecond tick. That tick drives a ripple of packed-BCD counters covering hundredths of seconds, seconds, minutes, hours (24-hour), day of week, day of month, month, year and a two-bit century. The whole time image is presented as eight byte-wide registers. A control agent loads the time through a one-byte write port.

Every accepted write, to any of the eight registers, clears the sub-second register and restarts the divider. The first centisecond after a write is therefore one full divider period away. The sub-second register itself can only ever be loaded with zero. A stop flag held in the seconds register freezes the divider and all counters until it is written back to zero.

The write port is a valid/ready sink. A beat transfers on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while reset is asserted and stays high from the first edge after reset, so the port never applies back-pressure in operation. A source may hold `wr_valid` high for consecutive beats, and each one is a separate write.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset the register image reads year 00, month 01, date 01, day of week 1, century 0, and hours, minutes, seconds and sub-seconds 00; `osc_running` is 1 and `wr_ready` is 0 during reset.
- R2: `wr_ready` is 1 from the first edge after reset onward, and an accepted write is visible on `clk_regs` after that edge.
- R3: Any accepted write sets the sub-second byte to 00 and restarts the divider, so the next centisecond arrives on exactly the DIV-th `osc_tick` after the write.
- R4: A write to address 0 stores 00 whatever the data.
- R5: Writing 1 to bit 7 of address 1 (the stop flag) drives `osc_running` low and freezes all counters; writing 0 there resumes counting.
- R6: Sub-seconds count 00 to 99 BCD; seconds and minutes count 00 to 59 BCD, each wrap carrying into the next field.
- R7: Hours count 00 to 23; a wrap past 23 advances the day of week (1 to 7, with 7 followed by 1) and the date.
- R8: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11; 29 for month 02 when the BCD year is divisible by 4, otherwise 28; 31 for the rest.
- R9: Month 12 wraps to 01 and advances the year; year 99 wraps to 00 and advances the century, which wraps from 3 to 0.
- R10: Byte n of `clk_regs` is bits [8n+7:8n]. Field layout: address 0 is the sub-second BCD in [7:0]. Address 1 holds the stop flag in bit 7 and seconds in [6:0]. Address 2 holds minutes in [6:0]. Address 3 holds the century in [7:6] and hours in [5:0]. Address 4 holds the day of week in [2:0]. Address 5 holds the date in [5:0]. Address 6 holds the month in [4:0]. Address 7 holds the year in [7:0]. Bits outside these fields are dropped on write and read as 0.
- R11: A write that coincides with a divider tick takes priority: the tick is discarded and no counter advances on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat can be accepted |
| wr_addr | input | 3 | Register address 0 to 7 |
| wr_data | input | 8 | Register write data |
| clk_regs | output | 64 | Live eight-byte register image, byte n at bits [8n+7:8n] |
| osc_running | output | 1 | High while the stop flag is clear |

## Verification
Every result is registered once. A write, and also an `osc_tick` that completes a divider period, shows on `clk_regs` after the next rising edge, with the full carry ripple from sub-seconds up to the century settled on that same edge. `osc_running` follows the stop flag after one edge, and `wr_ready` rises on the first edge after reset. The bench drives each stimulus at a falling edge, advances its reference model at the rising edge, and compares the whole image at the following falling edge. This keeps every comparison exactly one edge after its cause. Directed rollovers apply exactly DIV×100 strobes after a write, so the wrap lands on a known cycle.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_REGS = 8;
  localparam int IMG_W = NUM_REGS * 8;

  typedef logic [7:0] bcd8_t;

  // Next packed-BCD value, no range wrap.
  function automatic bcd8_t bcd_step(bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // Last valid date (BCD) of a month given the BCD year.
  function automatic bcd8_t month_last_day(bcd8_t mon, bcd8_t yr);
    logic [6:0] ybin;
    ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      8'h02: return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_prescaler.sv
module bcd_prescaler #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic halt,
  input  logic osc_tick,
  output logic cs_tick
);
  logic adv;
  assign adv = osc_tick && !halt && !restart;

  generate
    if (DIV <= 1) begin : g_direct
      assign cs_tick = adv;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      assign cs_tick = adv && (cnt == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (adv)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end

      // A restart leaves a full period before the next centisecond.
      assert_restart_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !cs_tick);
    end
  endgenerate

  assert_halt_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !cs_tick);
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !cs_tick);
endmodule

// File: rtl/bcd_time_chain.sv
module bcd_time_chain
  import bcd_clock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_tick,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        csec,
  output logic [6:0]        sec,
  output logic [6:0]        mins,
  output logic [5:0]        hour,
  output logic              stop,
  output logic              day_carry
);
  logic c_sec, c_min, c_hr;

  assign c_sec     = cs_tick && (csec >= 8'h99);
  assign c_min     = c_sec && (sec >= 7'h59);
  assign c_hr      = c_min && (mins >= 7'h59);
  assign day_carry = c_hr && (hour >= 6'h23);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csec <= '0;
      sec  <= '0;
      mins <= '0;
      hour <= '0;
      stop <= 1'b0;
    end else if (wr_fire) begin
      csec <= '0;
      case (wr_addr)
        3'd1: begin
          stop <= wr_data[7];
          sec  <= wr_data[6:0];
        end
        3'd2: mins <= wr_data[6:0];
        3'd3: hour <= wr_data[5:0];
        default: ;
      endcase
    end else begin
      if (cs_tick) csec <= c_sec ? 8'h00 : bcd_step(csec);
      if (c_sec)   sec  <= c_min ? 7'h00 : 7'(bcd_step({1'b0, sec}));
      if (c_min)   mins <= c_hr ? 7'h00 : 7'(bcd_step({1'b0, mins}));
      if (c_hr)    hour <= day_carry ? 6'h00 : 6'(bcd_step({2'b0, hour}));
    end
  end

  assert_csec_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (csec == 8'h00));
  assert_time_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_tick && !wr_fire) |=> $stable({csec, sec, mins, hour, stop}));
  assert_hour_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_tick && csec == 8'h99 && sec == 7'h59 && mins == 7'h59 && hour == 6'h23)
      |=> (hour == 6'h00 && csec == 8'h00));
  assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_tick && csec == 8'h99 && sec == 7'h59) |=> (sec == 7'h00));
endmodule

// File: rtl/bcd_date_chain.sv
module bcd_date_chain
  import bcd_clock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_carry,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [2:0]        dow,
  output logic [5:0]        date,
  output logic [4:0]        month,
  output logic [7:0]        year,
  output logic [1:0]        century
);
  logic mon_end, yr_end, c_mon, c_yr, c_cen;
  bcd8_t last_day;

  assign last_day = month_last_day({3'b0, month}, year);
  assign mon_end  = ({2'b0, date} >= last_day);
  assign yr_end   = (month >= 5'h12);
  assign c_mon    = day_carry && mon_end;
  assign c_yr     = c_mon && yr_end;
  assign c_cen    = c_yr && (year >= 8'h99);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow     <= 3'd1;
      date    <= 6'h01;
      month   <= 5'h01;
      year    <= 8'h00;
      century <= 2'd0;
    end else if (wr_fire) begin
      case (wr_addr)
        3'd3: century <= wr_data[7:6];
        3'd4: dow     <= wr_data[2:0];
        3'd5: date    <= wr_data[5:0];
        3'd6: month   <= wr_data[4:0];
        3'd7: year    <= wr_data;
        default: ;
      endcase
    end else if (day_carry) begin
      dow  <= (dow >= 3'd7) ? 3'd1 : dow + 3'd1;
      date <= mon_end ? 6'h01 : 6'(bcd_step({2'b0, date}));
      if (c_mon) month <= yr_end ? 5'h01 : 5'(bcd_step({3'b0, month}));
      if (c_yr)  year  <= c_cen ? 8'h00 : bcd_step(year);
      if (c_cen) century <= century + 2'd1;
    end
  end

  assert_date_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!day_carry && !wr_fire) |=> $stable({dow, date, month, year, century}));
  assert_century_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && year == 8'h99 && month == 5'h12 && date == 6'h31)
      |=> (year == 8'h00 && month == 5'h01 && century == ($past(century) + 2'd1)));
  assert_dow_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && dow == 3'd7) |=> (dow == 3'd1));
  assert_feb_leap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && month == 5'h02 && date == 6'h28 && year == 8'h24) |=> (date == 6'h29));
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import bcd_clock_pkg::*;
#(
  parameter int DIV = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [IMG_W-1:0]  clk_regs,
  output logic              osc_running
);
  logic       wr_fire, cs_tick, day_carry, stop;
  logic [7:0] csec, year;
  logic [6:0] sec, mins;
  logic [5:0] hour, date;
  logic [4:0] month;
  logic [2:0] dow;
  logic [1:0] century;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ready <= 1'b0;
    else        wr_ready <= 1'b1;
  end

  assign wr_fire = wr_valid && wr_ready;

  bcd_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(wr_fire), .halt(stop),
    .osc_tick(osc_tick), .cs_tick(cs_tick)
  );

  bcd_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .cs_tick(cs_tick), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .wr_data(wr_data), .csec(csec), .sec(sec),
    .mins(mins), .hour(hour), .stop(stop), .day_carry(day_carry)
  );

  bcd_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_carry(day_carry), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .wr_data(wr_data), .dow(dow), .date(date),
    .month(month), .year(year), .century(century)
  );

  assign clk_regs = {year, 3'b0, month, 2'b0, date, 5'b0, dow,
                     century, hour, 1'b0, mins, stop, sec, csec};
  assign osc_running = !stop;

  assert_ready_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> wr_ready);
  assert_addr0_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == 3'd0) |=> (clk_regs[7:0] == 8'h00));
endmodule

// File: tb/bcd_clock_core_tb.sv
module bcd_clock_core_tb;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [63:0] clk_regs;
  logic        osc_running;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_cs, m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_cen, m_pre;
  bit m_stop;

  always #4 clk = ~clk;

  bcd_clock_core #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_regs(clk_regs), .osc_running(osc_running)
  );

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_of(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] model_image();
    return {to_bcd(m_yr), to_bcd(m_mon), to_bcd(m_date), 5'b0, 3'(m_dow),
            2'(m_cen), to_bcd(m_hr)[5:0], to_bcd(m_min), m_stop, to_bcd(m_sec)[6:0],
            to_bcd(m_cs)};
  endfunction

  task automatic model_reset();
    m_cs = 0; m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1;
    m_mon = 1; m_yr = 0; m_cen = 0; m_pre = 0; m_stop = 0;
  endtask

  task automatic model_advance();
    m_cs++;
    if (m_cs < 100) return;
    m_cs = 0; m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_dow = (m_dow % 7) + 1;
    m_date++;
    if (m_date <= days_of(m_mon, m_yr)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr++;
    if (m_yr < 100) return;
    m_yr = 0; m_cen = (m_cen + 1) % 4;
  endtask

  task automatic model_step(bit o, bit fire, logic [2:0] a, logic [7:0] d);
    if (fire) begin
      m_cs = 0; m_pre = 0;
      case (a)
        3'd1: begin m_stop = d[7]; m_sec = from_bcd({1'b0, d[6:0]}); end
        3'd2: m_min = from_bcd({1'b0, d[6:0]});
        3'd3: begin m_cen = int'(d[7:6]); m_hr = from_bcd({2'b0, d[5:0]}); end
        3'd4: m_dow = int'(d[2:0]);
        3'd5: m_date = from_bcd({2'b0, d[5:0]});
        3'd6: m_mon = from_bcd({3'b0, d[4:0]});
        3'd7: m_yr = from_bcd(d);
        default: ;
      endcase
    end else if (!m_stop && o) begin
      if (m_pre == DIV - 1) begin m_pre = 0; model_advance(); end
      else m_pre++;
    end
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, take the edge, compare at the next fall.
  task automatic step(bit o, bit v, logic [2:0] a, logic [7:0] d);
    bit fire;
    fire = v && wr_ready;
    osc_tick = o; wr_valid = v; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_step(o, fire, a, d);
    @(negedge clk);
    osc_tick = 1'b0; wr_valid = 1'b0;
    check("R6 image", clk_regs, model_image());
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  function automatic logic [7:0] byte_of(int n);
    return clk_regs[8*n +: 8];
  endfunction

  task automatic set_time(logic [7:0] cen_hr, logic [7:0] mn, logic [7:0] s,
                          logic [7:0] dw, logic [7:0] dt, logic [7:0] mo, logic [7:0] yr);
    wr(3'd7, yr); wr(3'd6, mo); wr(3'd5, dt); wr(3'd4, dw);
    wr(3'd3, cen_hr); wr(3'd2, mn); wr(3'd1, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset image and status
    check("R1 image", clk_regs, 64'h00010101_00000000);
    check("R1 running", {63'b0, osc_running}, 64'd1);
    check("R1 ready low", {63'b0, wr_ready}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 ready", {63'b0, wr_ready}, 64'd1);

    // R6: counting from reset
    run(3 * DIV + 1);
    check("R6 csec", {56'b0, byte_of(0)}, 64'h03);
    // R4: sub-second write stores zero
    wr(3'd0, 8'h55);
    check("R4 csec", {56'b0, byte_of(0)}, 64'h00);

    // R3: divider restarts on a write
    wr(3'd2, 8'h10);
    check("R2 minutes", {56'b0, byte_of(2)}, 64'h10);
    run(DIV - 1);
    check("R3 before period", {56'b0, byte_of(0)}, 64'h00);
    run(1);
    check("R3 at period", {56'b0, byte_of(0)}, 64'h01);

    // R11: write on the tick edge wins
    run(DIV - 1);
    step(1'b1, 1'b1, 3'd2, 8'h20);
    check("R11 csec", {56'b0, byte_of(0)}, 64'h00);
    run(DIV);
    check("R11 next tick", {56'b0, byte_of(0)}, 64'h01);

    // R10: masked fields
    wr(3'd4, 8'hFF); check("R10 dow", {56'b0, byte_of(4)}, 64'h07);
    wr(3'd6, 8'hF2); check("R10 month", {56'b0, byte_of(6)}, 64'h12);
    wr(3'd2, 8'hB0); check("R10 minutes", {56'b0, byte_of(2)}, 64'h30);
    wr(3'd3, 8'h63); check("R10 century hours", {56'b0, byte_of(3)}, 64'h63);
    wr(3'd5, 8'hE9); check("R10 date", {56'b0, byte_of(5)}, 64'h29);

    // R6: minute carry
    set_time(8'h05, 8'h09, 8'h59, 8'h03, 8'h10, 8'h05, 8'h30);
    run(100 * DIV);
    check("R6 minutes", {56'b0, byte_of(2)}, 64'h10);
    check("R6 seconds", {56'b0, byte_of(1)}, 64'h00);

    // R7 R8: non-leap February end
    set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h28, 8'h02, 8'h23);
    run(100 * DIV);
    check("R8 date", {56'b0, byte_of(5)}, 64'h01);
    check("R8 month", {56'b0, byte_of(6)}, 64'h03);
    check("R7 dow", {56'b0, byte_of(4)}, 64'h01);
    check("R7 hours", {56'b0, byte_of(3)}, 64'h00);

    // R8: leap February
    set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h24);
    run(100 * DIV);
    check("R8 leap date", {56'b0, byte_of(5)}, 64'h29);
    check("R7 dow step", {56'b0, byte_of(4)}, 64'h03);

    // R8: 30-day month
    set_time(8'h23, 8'h59, 8'h59, 8'h04, 8'h30, 8'h04, 8'h11);
    run(100 * DIV);
    check("R8 april end", {48'b0, byte_of(6), byte_of(5)}, 64'h0501);

    // R9: year and century wrap
    set_time(8'hE3, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    run(100 * DIV);
    check("R9 year", {56'b0, byte_of(7)}, 64'h00);
    check("R9 century", {56'b0, byte_of(3)}, 64'h00);
    check("R9 month", {56'b0, byte_of(6)}, 64'h01);

    // R5: stop and resume
    wr(3'd1, 8'h80);
    check("R5 stopped", {63'b0, osc_running}, 64'd0);
    run(10 * DIV);
    check("R5 frozen", {48'b0, byte_of(1), byte_of(0)}, 64'h8000);
    wr(3'd1, 8'h00);
    check("R5 resumed", {63'b0, osc_running}, 64'd1);
    run(DIV);
    check("R5 counting", {56'b0, byte_of(0)}, 64'h01);

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bit o, v;
      logic [2:0] a;
      logic [7:0] d;
      o = ($urandom % 4) != 0;
      v = ($urandom % 20) == 0;
      a = 3'($urandom % 8);
      case (a)
        3'd0: d = 8'($urandom);
        3'd1: d = {(($urandom % 8) == 0) ? 1'b1 : 1'b0, to_bcd($urandom % 60)[6:0]};
        3'd2: d = to_bcd($urandom % 60);
        3'd3: d = {2'($urandom), to_bcd($urandom % 24)[5:0]};
        3'd4: d = 8'(1 + $urandom % 7);
        3'd5: d = to_bcd(1 + $urandom % 28);
        3'd6: d = to_bcd(1 + $urandom % 12);
        default: d = to_bcd($urandom % 100);
      endcase
      step(o, v, a, d);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule